// File: doc/BRIEF.md
# ALU with Rotator and Skip Test

This block is the combinational execution unit of a small register-machine core. On each evaluation it takes a 3-bit operation selector, a 2-bit rotate selector, a 2-bit skip selector, two 32-bit operands and an input-ready flag. It produces three outputs: a 32-bit result, a skip flag and a reserved-operation flag. The chosen operation runs first. Its output then passes through a right rotator, and the rotated word is the value that leaves the block.

The sequencer uses the skip flag to pick the next instruction address. When the flag is high, the address advances by two. When it is low, the address advances by one. The skip test looks at the rotated result, except for one selector value, which looks at the input-ready flag instead. Register access, memories, decode and program-counter storage sit outside this block. There is no clock: the outputs follow the inputs within the same cycle.

Top module: `aluRotSkip`

## Requirements
- R1: Operation code 0 gives opA+opB and code 1 gives opA-opB, both modulo 2^32. No carry or overflow is reported.
- R2: Operation code 2 gives opB+1 and code 3 gives opB-1, both modulo 2^32. The value of opA has no effect on the result for these codes.
- R3: Operation codes 4, 5 and 6 give the bitwise AND, OR and XOR of opA and opB.
- R4: Operation code 7 drives reserved high and forces result to zero, whatever the rotate selector. For every other code, reserved is low.
- R5: The rotator acts on the output of the operation, not on the operands. Rotate code 0 passes the value through. Codes 1, 2 and 3 rotate right by 1, 8 and 16 bit positions.
- R6: Skip code 0 never skips. Code 1 skips when bit 31 of the rotated result is 1. Code 2 skips when the rotated result is all zeros. Code 3 skips when inReady is high. For code 7, the test applies to the forced-zero result.
- R7: inReady only affects skip, and only under skip code 3. It never changes result or reserved.
- R8: All outputs are a combinational function of the present inputs and hold no state between cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| funcCode | input | 3 | Operation selector (0 add, 1 sub, 2 inc B, 3 dec B, 4 and, 5 or, 6 xor, 7 reserved) |
| rotCode | input | 2 | Right-rotate selector (0 none, 1 by 1, 2 by 8, 3 by 16) |
| skipCode | input | 2 | Skip test selector (0 never, 1 negative, 2 zero, 3 input ready) |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| inReady | input | 1 | Input-ready flag, used only by skip code 3 |
| result | output | 32 | Rotated result of the operation |
| skip | output | 1 | High when the next address should advance by two |
| reserved | output | 1 | High when operation code 7 is presented |

## Verification
The bench drives every combination of operation, rotate and skip code against the operand values 0, 0xFFFFFFFF, 0x80000000 and 1, plus random words.

Each corner case targets a specific fault:
- Incrementing 0xFFFFFFFF and decrementing 0 catch a design that does not wrap, or that feeds opA into the increment path.
- A sign bit that moves under rotation (0x80000000 rotated by 1, or a value with bit 0 set) catches a design that tests the sign before rotating, or that rotates the operands.
- Operation code 7 with a zero skip test catches a design that leaves garbage on the result or skips on stale data.
- Toggling inReady under the other skip codes catches a design that leaks it into the result or into the wrong test.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0, FN_SUB = 3'd1, FN_INC = 3'd2, FN_DEC = 3'd3,
    FN_AND = 3'd4, FN_OR = 3'd5, FN_XOR = 3'd6, FN_RSV = 3'd7
  } funcE;

  typedef enum logic [1:0] {
    LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2
  } logicOpE;

  typedef enum logic [1:0] {
    SK_NEVER = 2'd0, SK_NEG = 2'd1, SK_ZERO = 2'd2, SK_READY = 2'd3
  } skipE;

  // Strobes from control to datapath
  typedef struct packed {
    logic    xIsB;      // adder left input takes opB
    logic    yZero;     // adder right input starts from zero
    logic    yInvert;   // adder right input is inverted
    logic    carryIn;   // adder carry in
    logic    selLogic;  // result taken from the logic unit
    logicOpE logicOp;
    logic    zeroOut;   // force the function output to zero
    logic [1:0] rotSel;
    skipE    skipSel;
  } ctrlT;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic [2:0] funcCode,
  input  logic [1:0] rotCode,
  input  logic [1:0] skipCode,
  output ctrlT       ctrl,
  output logic       reservedOp
);

  funcE fn;
  assign fn = funcE'(funcCode);

  always_comb begin
    ctrl          = '0;
    ctrl.rotSel   = rotCode;
    ctrl.skipSel  = skipE'(skipCode);
    ctrl.logicOp  = LG_AND;
    reservedOp    = 1'b0;
    unique case (fn)
      FN_ADD: ;
      FN_SUB: begin ctrl.yInvert = 1'b1; ctrl.carryIn = 1'b1; end
      FN_INC: begin ctrl.xIsB = 1'b1; ctrl.yZero = 1'b1; ctrl.carryIn = 1'b1; end
      FN_DEC: begin ctrl.xIsB = 1'b1; ctrl.yZero = 1'b1; ctrl.yInvert = 1'b1; end
      FN_AND: begin ctrl.selLogic = 1'b1; ctrl.logicOp = LG_AND; end
      FN_OR:  begin ctrl.selLogic = 1'b1; ctrl.logicOp = LG_OR;  end
      FN_XOR: begin ctrl.selLogic = 1'b1; ctrl.logicOp = LG_XOR; end
      FN_RSV: begin ctrl.zeroOut = 1'b1; reservedOp = 1'b1; end
      default: ;
    endcase
  end

  // R2: increment/decrement must never route opA into the adder
  always_comb begin
    if (fn == FN_INC || fn == FN_DEC)
      a_r2_b_only: assert (ctrl.xIsB && ctrl.yZero)
        else $error("inc/dec must use opB only");
  end

endmodule

// File: rtl/aluAdder.sv
module aluAdder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             xIsB,
  input  logic             yZero,
  input  logic             yInvert,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum
);

  logic [WIDTH-1:0] xIn, yBase, yIn;

  always_comb begin
    xIn   = xIsB  ? opB : opA;
    yBase = yZero ? '0  : opB;
    yIn   = yInvert ? ~yBase : yBase;
    sum   = xIn + yIn + WIDTH'(carryIn);   // wraps modulo 2^WIDTH
  end

endmodule

// File: rtl/aluLogic.sv
module aluLogic
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logicOpE          op,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    unique case (op)
      LG_AND:  res = opA & opB;
      LG_OR:   res = opA | opB;
      LG_XOR:  res = opA ^ opB;
      default: res = opA & opB;
    endcase
  end

endmodule

// File: rtl/aluRotator.sv
module aluRotator #(
  parameter int WIDTH  = 32,
  parameter int AMT_1  = 1,
  parameter int AMT_2  = 8,
  parameter int AMT_3  = 16
) (
  input  logic [WIDTH-1:0] din,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] dout
);

  localparam int NUM_AMT = 4;
  localparam int AMTS [NUM_AMT] = '{0, AMT_1, AMT_2, AMT_3};

  logic [WIDTH-1:0] cand [NUM_AMT];

  // One fixed-distance right rotation per selector value
  for (genvar g = 0; g < NUM_AMT; g++) begin : gRot
    if (AMTS[g] == 0) begin : gPass
      assign cand[g] = din;
    end else begin : gTurn
      assign cand[g] = {din[AMTS[g]-1:0], din[WIDTH-1:AMTS[g]]};
    end
  end

  assign dout = cand[sel];

  // R5: rotation keeps the population count
  always_comb begin
    a_r5_bits_kept: assert ($countones(dout) == $countones(din))
      else $error("rotator lost bits");
  end

endmodule

// File: rtl/aluSkipEval.sv
module aluSkipEval
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  input  skipE             sel,
  input  logic             inReady,
  output logic             skip
);

  always_comb begin
    unique case (sel)
      SK_NEVER: skip = 1'b0;
      SK_NEG:   skip = value[WIDTH-1];
      SK_ZERO:  skip = (value == '0);
      SK_READY: skip = inReady;
      default:  skip = 1'b0;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_1 = 1,
  parameter int AMT_2 = 8,
  parameter int AMT_3 = 16
) (
  input  ctrlT             ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             inReady,
  output logic [WIDTH-1:0] result,
  output logic             skip
);

  logic [WIDTH-1:0] sumOut, logicOut, funcOut;

  aluAdder #(.WIDTH(WIDTH)) uAdder (
    .opA(opA), .opB(opB),
    .xIsB(ctrl.xIsB), .yZero(ctrl.yZero),
    .yInvert(ctrl.yInvert), .carryIn(ctrl.carryIn),
    .sum(sumOut)
  );

  aluLogic #(.WIDTH(WIDTH)) uLogic (
    .opA(opA), .opB(opB), .op(ctrl.logicOp), .res(logicOut)
  );

  always_comb begin
    if (ctrl.zeroOut)       funcOut = '0;
    else if (ctrl.selLogic) funcOut = logicOut;
    else                    funcOut = sumOut;
  end

  aluRotator #(.WIDTH(WIDTH), .AMT_1(AMT_1), .AMT_2(AMT_2), .AMT_3(AMT_3)) uRot (
    .din(funcOut), .sel(ctrl.rotSel), .dout(result)
  );

  aluSkipEval #(.WIDTH(WIDTH)) uSkip (
    .value(result), .sel(ctrl.skipSel), .inReady(inReady), .skip(skip)
  );

  // R6: the sign test reads the rotated word, not the pre-rotation one
  always_comb begin
    if (ctrl.skipSel == SK_NEG)
      a_r6_sign_after_rot: assert (skip == result[WIDTH-1])
        else $error("negative test not on rotated value");
  end

endmodule

// File: rtl/aluRotSkip.sv
module aluRotSkip
  import aluPkg::*;
(
  input  logic [2:0]  funcCode,
  input  logic [1:0]  rotCode,
  input  logic [1:0]  skipCode,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        inReady,
  output logic [31:0] result,
  output logic        skip,
  output logic        reserved
);

  localparam int WIDTH = 32;

  ctrlT ctrl;

  aluCtrl uCtrl (
    .funcCode(funcCode), .rotCode(rotCode), .skipCode(skipCode),
    .ctrl(ctrl), .reservedOp(reserved)
  );

  aluDatapath #(.WIDTH(WIDTH)) uDp (
    .ctrl(ctrl), .opA(opA), .opB(opB), .inReady(inReady),
    .result(result), .skip(skip)
  );

  always_comb begin
    // R4: reserved code yields a zero word
    if (reserved)
      a_r4_reserved_zero: assert (result == '0)
        else $error("reserved code gave nonzero result");
    // R6: never-skip selector
    if (skipCode == 2'd0)
      a_r6_never_skip: assert (!skip)
        else $error("skip under never code");
    // R6: zero test
    if (skipCode == 2'd2)
      a_r6_zero_skip: assert (skip == (result == '0))
        else $error("zero test mismatch");
    // R3: unrotated AND
    if (funcCode == 3'd4 && rotCode == 2'd0)
      a_r3_and_pass: assert (result == (opA & opB))
        else $error("and mismatch");
  end

endmodule

// File: tb/tb_aluRotSkip.sv
module tb_aluRotSkip;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [2:0]  funcCode = '0;
  logic [1:0]  rotCode  = '0;
  logic [1:0]  skipCode = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        inReady = 1'b0;
  logic [31:0] result;
  logic        skip, reserved;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  aluRotSkip dut (
    .funcCode(funcCode), .rotCode(rotCode), .skipCode(skipCode),
    .opA(opA), .opB(opB), .inReady(inReady),
    .result(result), .skip(skip), .reserved(reserved)
  );

  // Behavioural reference
  function automatic logic [31:0] refFunc(int f, logic [31:0] a, logic [31:0] b);
    case (f)
      0: return a + b;
      1: return a - b;
      2: return b + 32'd1;
      3: return b - 32'd1;
      4: return a & b;
      5: return a | b;
      6: return a ^ b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] refRot(int r, logic [31:0] v);
    int n;
    logic [63:0] dbl;
    n = (r == 0) ? 0 : (r == 1) ? 1 : (r == 2) ? 8 : 16;
    dbl = {v, v} >> n;
    return dbl[31:0];
  endfunction

  function automatic bit refSkip(int s, logic [31:0] v, bit rdy);
    case (s)
      0: return 1'b0;
      1: return v[31];
      2: return v == 32'd0;
      default: return rdy;
    endcase
  endfunction

  function automatic string resTag(int f, int r);
    if (f == 7) return "R4";
    if (r != 0) return "R5";
    if (f < 2)  return "R1";
    if (f < 4)  return "R2";
    return "R3";
  endfunction

  task automatic applyCheck(int f, int r, int s, logic [31:0] a, logic [31:0] b, bit rdy);
    logic [31:0] expRes;
    bit expSkip, expRsv;
    @(posedge clk);
    #2;
    funcCode = 3'(f); rotCode = 2'(r); skipCode = 2'(s);
    opA = a; opB = b; inReady = rdy;
    expRes  = refRot(r, refFunc(f, a, b));
    expSkip = refSkip(s, expRes, rdy);
    expRsv  = (f == 7);
    @(negedge clk);
    total++;
    if (result !== expRes || skip !== expSkip || reserved !== expRsv) begin
      bad++;
      if (result !== expRes)
        $display("FAIL %s result f=%0d r=%0d a=%h b=%h act=%h exp=%h",
                 resTag(f, r), f, r, a, b, result, expRes);
      if (skip !== expSkip)
        $display("FAIL R6 skip s=%0d rdy=%0d act=%0b exp=%0b", s, rdy, skip, expSkip);
      if (reserved !== expRsv)
        $display("FAIL R4 reserved f=%0d act=%0b exp=%0b", f, reserved, expRsv);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] corners [5];
    logic [31:0] resHold;
    corners[0] = 32'h0000_0000;
    corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h8000_0000;
    corners[3] = 32'h0000_0001;
    corners[4] = 32'h1234_5678;

    // R8: idle inputs give an all-zero add with no flags
    applyCheck(0, 0, 0, 32'd0, 32'd0, 1'b0);

    // R1 R2 R3 R4 R5 R6: all codes over corner operands
    for (int f = 0; f < 8; f++)
      for (int r = 0; r < 4; r++)
        for (int s = 0; s < 4; s++)
          for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
              applyCheck(f, r, s, corners[i], corners[j], ((i + j + s) % 2) == 1);

    // R2: opA has no effect on inc/dec (wrap at 0xFFFFFFFF and 0)
    applyCheck(2, 0, 2, 32'h5555_5555, 32'hFFFF_FFFF, 1'b0);
    applyCheck(2, 0, 2, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 1'b0);
    applyCheck(3, 0, 1, 32'h0F0F_0F0F, 32'h0000_0000, 1'b0);

    // R5 R6: sign bit produced by rotation only
    applyCheck(4, 1, 1, 32'h0000_0001, 32'h0000_0001, 1'b0);
    applyCheck(4, 1, 1, 32'h8000_0000, 32'h8000_0000, 1'b0);

    // R7: inReady toggled under a non-ready skip code keeps result
    applyCheck(6, 2, 1, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b0);
    resHold = result;
    applyCheck(6, 2, 1, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b1);
    total++;
    if (result !== resHold) begin
      bad++;
      $display("FAIL R7 result changed by inReady act=%h exp=%h", result, resHold);
    end

    // R1..R6 under random operands
    for (int k = 0; k < 4000; k++)
      applyCheck(int'($urandom_range(7, 0)), int'($urandom_range(3, 0)),
                 int'($urandom_range(3, 0)), $urandom, $urandom, 1'($urandom));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule